// File: doc/BRIEF.md
# Clock-Control Register Bank

This block holds the software-visible state of a reset-and-clock controller: oscillator control, clock configuration, three PLL configuration words, interrupt enables and flags, per-bus peripheral reset, clock-enable and sleep-enable words, a kernel clock selection word, a backup-domain word and a control/status word. All of it sits in a 0x400-byte window of 32-bit registers reached over a simple valid/write bus. Only aligned word accesses take effect. Read data comes back one cycle after the request.

Most words are plain storage. A few have bits that software cannot change (read-only) or cannot clear once set (set-only). Interrupt flags are raised by hardware through a flag-set input. Software cannot write them directly. It clears them by writing ones to a separate clear word, and that clear word always reads as zero. A single level interrupt goes high whenever any flag inside a fixed source mask is set.

Top module: `ccr_regbank`

## Requirements
- R1: Word `n` (0 to 29) sits at byte offset `4*n`, in this order: oscillator control, calibration, clock config, PLL config A, PLL config B, PLL config C, interrupt enable, interrupt flags, interrupt clear, six peripheral reset words, six clock-enable words, six sleep-enable words, kernel clock select, backup domain, control/status.
- R2: After reset the words read: oscillator control 0x00000063, calibration 0x106E0082, each PLL config 0x00001000, first clock-enable 0x00000100, sleep-enable words 0x00011303, 0x000532FF, 0x00000101, 0xF2FECA3F, 0x00000025 and 0x01677C01, control/status 0x0C000600, and every other word 0. The interrupt output is low.
- R3: A read request (`bus_valid`=1, `bus_write`=0) gives `bus_rvalid`=1 with the data on `bus_rdata` in the next cycle. `bus_rvalid` is 0 in any cycle that does not follow a read request.
- R4: The PLL config, interrupt enable, peripheral reset, first five clock-enable, sleep-enable and kernel clock select words store all 32 written bits.
- R5: In the oscillator control word, bits under 0x0A020402 are read-only and keep their value. Bit 19 (0x00080000) is set-only: once it is 1, a write of 0 does not clear it. All other bits take the written value.
- R6: Read-only bits keep their value on write in the calibration word (bits [7:0]), the clock config word (bits [3:2]), the backup-domain word (mask 0x00000842) and the control/status word (mask 0xFF000002). All other bits in these words take the written value.
- R7: In the sixth clock-enable word (offset 0x50), bit 0 is set-only. A write ORs the written value with that held bit. All other bits take the written value.
- R8: A write to the interrupt flag word (offset 0x1C) is ignored and leaves the flags unchanged.
- R9: Writing a 1 to a bit of the interrupt clear word (offset 0x20) clears the matching flag at the next clock edge. Reading the clear word returns 0.
- R10: On each clock edge, every bit set on `flag_set` is ORed into the flags. If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R11: `irq` is 1 exactly when the flags ANDed with `IRQ_SRC_MASK` (default 0x000007FF) are non-zero. It follows a flag change with no extra register stage.
- R12: An access is ignored if its offset is not a multiple of 4, or if it is 0x78 or above within the window. Such a write changes nothing, and such a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (10) | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| flag_set | input | 32 | Hardware flag-set bits, ORed into the flags at the edge |
| irq | output | 1 | Level interrupt |

## Verification
A write takes effect at the clock edge that samples it. Read data and `bus_rvalid` appear one cycle after the read request. The flags, and with them `irq`, change at the edge that samples `flag_set` or a clear write.

The bench drives every input half a cycle before an edge. It samples `irq` at the falling edge that follows the edge carrying the stimulus. It checks read data at the falling edge after the capturing edge, which makes every register effect visible exactly one cycle after the request. The checker states the same latencies as single-step implications.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int REG_W    = 32;
    localparam int NUM_REGS = 30;
    localparam int IDX_W    = $clog2(NUM_REGS);

    // word indices whose behaviour is special
    localparam int IDX_OSC    = 0;
    localparam int IDX_CAL    = 1;
    localparam int IDX_CFG    = 2;
    localparam int IDX_FLAG   = 7;
    localparam int IDX_CLR    = 8;
    localparam int IDX_EN6    = 20;
    localparam int IDX_BKP    = 28;
    localparam int IDX_STAT   = 29;

    localparam logic [REG_W-1:0] OSC_RO_MASK  = 32'h0A020402;
    localparam logic [REG_W-1:0] OSC_SET_MASK = 32'h00080000;
    localparam logic [REG_W-1:0] CAL_RO_MASK  = 32'h000000FF;
    localparam logic [REG_W-1:0] CFG_RO_MASK  = 32'h0000000C;
    localparam logic [REG_W-1:0] BKP_RO_MASK  = 32'h00000842;
    localparam logic [REG_W-1:0] STAT_RO_MASK = 32'hFF000002;
    localparam logic [REG_W-1:0] EN6_SET_MASK = 32'h00000001;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [IDX_W-1:0] idx;
    } access_t;

    function automatic logic [REG_W-1:0] reset_value(input int idx);
        logic [REG_W-1:0] v;
        case (idx)
            0:       v = 32'h00000063;
            1:       v = 32'h106E0082;
            3, 4, 5: v = 32'h00001000;
            15:      v = 32'h00000100;
            21:      v = 32'h00011303;
            22:      v = 32'h000532FF;
            23:      v = 32'h00000101;
            24:      v = 32'hF2FECA3F;
            25:      v = 32'h00000025;
            26:      v = 32'h01677C01;
            29:      v = 32'h0C000600;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic [REG_W-1:0] ro_mask(input int idx);
        logic [REG_W-1:0] m;
        case (idx)
            IDX_OSC:  m = OSC_RO_MASK;
            IDX_CAL:  m = CAL_RO_MASK;
            IDX_CFG:  m = CFG_RO_MASK;
            IDX_BKP:  m = BKP_RO_MASK;
            IDX_STAT: m = STAT_RO_MASK;
            default:  m = '0;
        endcase
        return m;
    endfunction

    function automatic logic [REG_W-1:0] set_mask(input int idx);
        logic [REG_W-1:0] m;
        case (idx)
            IDX_OSC: m = OSC_SET_MASK;
            IDX_EN6: m = EN6_SET_MASK;
            default: m = '0;
        endcase
        return m;
    endfunction

    // held bits (read-only or set-only) keep the old value; the rest follow the write
    function automatic logic [REG_W-1:0] merge_write(
        input logic [REG_W-1:0] old_v,
        input logic [REG_W-1:0] wdata,
        input logic [REG_W-1:0] ro,
        input logic [REG_W-1:0] so
    );
        return (old_v & (ro | so)) | (wdata & ~ro);
    endfunction

endpackage

// File: rtl/ccr_bus_decode.sv
module ccr_bus_decode
    import ccr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output access_t           acc,
    output logic              rd_req
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              in_map;

    always_comb begin
        word    = bus_addr[ADDR_W-1:2];
        aligned = (bus_addr[1:0] == 2'b00);
        in_map  = (int'(word) < NUM_REGS);
        rd_req  = bus_valid && !bus_write;
        acc.rd  = rd_req && aligned && in_map;
        acc.wr  = bus_valid && bus_write && aligned && in_map;
        acc.idx = in_map ? IDX_W'(word) : '0;
    end
endmodule

// File: rtl/ccr_reg_slots.sv
module ccr_reg_slots
    import ccr_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  access_t                        acc,
    input  logic [REG_W-1:0]               wdata,
    output logic [NUM_REGS-1:0][REG_W-1:0] slot_q
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        if (i == IDX_FLAG || i == IDX_CLR) begin : g_none
            assign slot_q[i] = '0;
        end else begin : g_reg
            localparam logic [REG_W-1:0] RST_V = reset_value(i);
            localparam logic [REG_W-1:0] RO_M  = ro_mask(i);
            localparam logic [REG_W-1:0] SO_M  = set_mask(i);
            logic [REG_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= RST_V;
                end else if (acc.wr && int'(acc.idx) == i) begin
                    q <= merge_write(q, wdata, RO_M, SO_M);
                end
            end
            assign slot_q[i] = q;
        end
    end
endmodule

// File: rtl/ccr_irq_flags.sv
module ccr_irq_flags
    import ccr_pkg::*;
#(
    parameter logic [REG_W-1:0] IRQ_SRC_MASK = 32'h000007FF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_wr,
    input  logic [REG_W-1:0] clr_bits,
    input  logic [REG_W-1:0] set_bits,
    output logic [REG_W-1:0] flags_q,
    output logic             irq
);
    logic [REG_W-1:0] clr_eff;

    always_comb clr_eff = clr_wr ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr_eff) | set_bits;
    end

    always_comb irq = |(flags_q & IRQ_SRC_MASK);
endmodule

// File: rtl/ccr_regbank.sv
module ccr_regbank
    import ccr_pkg::*;
#(
    parameter int               ADDR_W       = 10,
    parameter logic [31:0]      IRQ_SRC_MASK = 32'h000007FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [31:0]       flag_set,
    output logic              irq
);
    access_t                        acc;
    logic                           rd_req;
    logic [NUM_REGS-1:0][REG_W-1:0] slot_q;
    logic [REG_W-1:0]               flags_q;
    logic [REG_W-1:0]               rd_mux;
    logic                           clr_wr;

    ccr_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .acc       (acc),
        .rd_req    (rd_req)
    );

    ccr_reg_slots u_slots (
        .clk    (clk),
        .rst    (rst),
        .acc    (acc),
        .wdata  (bus_wdata),
        .slot_q (slot_q)
    );

    always_comb clr_wr = acc.wr && int'(acc.idx) == IDX_CLR;

    ccr_irq_flags #(.IRQ_SRC_MASK(IRQ_SRC_MASK)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .clr_wr   (clr_wr),
        .clr_bits (bus_wdata),
        .set_bits (flag_set),
        .flags_q  (flags_q),
        .irq      (irq)
    );

    always_comb begin
        rd_mux = '0;
        if (acc.rd) begin
            if (int'(acc.idx) == IDX_FLAG) rd_mux = flags_q;
            else                           rd_mux = slot_q[acc.idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rdata  <= rd_mux;
            bus_rvalid <= rd_req;
        end
    end
endmodule

// File: rtl/ccr_regbank_checker.sv
module ccr_regbank_checker #(
    parameter int          ADDR_W       = 10,
    parameter logic [31:0] IRQ_SRC_MASK = 32'h000007FF
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic [31:0]       flag_set,
    input logic              irq
);
    localparam logic [ADDR_W-1:0] CLR_OFF  = ADDR_W'(32'h20);
    localparam logic [ADDR_W-1:0] LAST_OFF = ADDR_W'(32'h74);

    logic rd_now, clr_all, quiet, bad_rd;
    always_comb begin
        rd_now  = bus_valid && !bus_write;
        clr_all = bus_valid && bus_write && bus_addr == CLR_OFF && bus_wdata == '1;
        quiet   = !(bus_valid && bus_write && bus_addr == CLR_OFF) && flag_set == '0;
        bad_rd  = rd_now && (bus_addr[1:0] != 2'b00 || bus_addr > LAST_OFF);
    end

    AST_RVALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
        rd_now |=> bus_rvalid);  // R3
    AST_RVALID_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        !rd_now |=> !bus_rvalid);  // R3
    AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_now && bus_addr == CLR_OFF) |=> bus_rdata == '0);  // R9
    AST_FULL_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (clr_all && flag_set == '0) |=> !irq);  // R9
    AST_SET_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        ((flag_set & IRQ_SRC_MASK) != '0) |=> irq);  // R10
    AST_IRQ_HOLDS_WHEN_QUIET: assert property (@(posedge clk) disable iff (rst)
        quiet |=> $stable(irq));  // R11
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        bad_rd |=> bus_rdata == '0);  // R12
endmodule

bind ccr_regbank ccr_regbank_checker #(
    .ADDR_W(ADDR_W), .IRQ_SRC_MASK(IRQ_SRC_MASK)
) u_checker (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .flag_set(flag_set), .irq(irq)
);

// File: tb/ccr_regbank_test.sv
module ccr_regbank_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [31:0] flag_set = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    ccr_regbank uut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .flag_set(flag_set), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata; v = bus_rvalid;
    endtask

    task automatic rd_check(input string tag, input logic [9:0] a, input logic [31:0] exp);
        logic [31:0] d; logic v;
        rd(a, d, v);
        check(tag, d, exp);
    endtask

    task automatic pulse_set(input logic [31:0] bits);
        @(negedge clk);
        flag_set = bits;
        @(negedge clk);
        flag_set = '0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic v;
        check("R2 irq after reset", {31'b0, irq}, 32'h0);
        check("R3 rvalid idle", {31'b0, bus_rvalid}, 32'h0);
        rd(10'h000, d, v);
        check("R2 osc ctrl reset", d, 32'h00000063);
        check("R3 rvalid after read", {31'b0, v}, 32'h1);
        rd_check("R2 calib reset", 10'h004, 32'h106E0082);
        rd_check("R2 clk cfg reset", 10'h008, 32'h0);
        rd_check("R2 pll A reset", 10'h00C, 32'h00001000);
        rd_check("R2 pll C reset", 10'h014, 32'h00001000);
        rd_check("R2 enable1 reset", 10'h03C, 32'h00000100);
        rd_check("R2 sleep1 reset", 10'h054, 32'h00011303);
        rd_check("R2 sleep4 reset", 10'h060, 32'hF2FECA3F);
        rd_check("R2 sleep6 reset", 10'h068, 32'h01677C01);
        rd_check("R2 status reset", 10'h074, 32'h0C000600);
        rd_check("R2 flags reset", 10'h01C, 32'h0);
    endtask

    task automatic t_plain();
        wr(10'h06C, 32'hA5A55A5A);
        rd_check("R4 kernel select store", 10'h06C, 32'hA5A55A5A);
        wr(10'h018, 32'h0000FFFF);
        rd_check("R1 R4 int enable at 0x18", 10'h018, 32'h0000FFFF);
        wr(10'h024, 32'h12345678);
        rd_check("R1 R4 reset word1 at 0x24", 10'h024, 32'h12345678);
        rd_check("R1 pll B untouched", 10'h010, 32'h00001000);
    endtask

    task automatic t_osc();
        wr(10'h000, 32'hFFFFFFFF);
        rd_check("R5 osc all ones", 10'h000, 32'hF5FDFBFF);
        wr(10'h000, 32'h00000000);
        rd_check("R5 osc set-only held", 10'h000, 32'h00080002);
    endtask

    task automatic t_readonly();
        wr(10'h004, 32'h12345655);
        rd_check("R6 calib low byte held", 10'h004, 32'h12345682);
        wr(10'h008, 32'hFFFFFFFF);
        rd_check("R6 cfg status bits held", 10'h008, 32'hFFFFFFF3);
        wr(10'h070, 32'hFFFFFFFF);
        rd_check("R6 backup ro bits", 10'h070, 32'hFFFFF7BD);
        wr(10'h074, 32'h00000000);
        rd_check("R6 status ro byte", 10'h074, 32'h0C000000);
    endtask

    task automatic t_en6();
        wr(10'h050, 32'h00000001);
        rd_check("R7 en6 set", 10'h050, 32'h00000001);
        wr(10'h050, 32'h00000000);
        rd_check("R7 en6 not cleared", 10'h050, 32'h00000001);
        wr(10'h050, 32'h00000010);
        rd_check("R7 en6 or", 10'h050, 32'h00000011);
    endtask

    task automatic t_flags();
        pulse_set(32'h00000005);
        check("R11 irq after set", {31'b0, irq}, 32'h1);
        rd_check("R10 flags set", 10'h01C, 32'h00000005);
        wr(10'h01C, 32'h00000000);
        rd_check("R8 flag write ignored", 10'h01C, 32'h00000005);
        wr(10'h020, 32'h00000001);
        rd_check("R9 clear one bit", 10'h01C, 32'h00000004);
        check("R11 irq still high", {31'b0, irq}, 32'h1);
        rd_check("R9 clear reads zero", 10'h020, 32'h0);
        wr(10'h020, 32'h00000004);
        check("R9 R11 irq low after clear", {31'b0, irq}, 32'h0);
        pulse_set(32'h00000800);
        check("R11 irq ignores unmasked", {31'b0, irq}, 32'h0);
        rd_check("R10 unmasked flag held", 10'h01C, 32'h00000800);
        wr(10'h020, 32'hFFFFFFFF);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 10'h020;
        bus_wdata = 32'h00000008; flag_set = 32'h00000008;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; flag_set = '0;
        rd_check("R10 set wins over clear", 10'h01C, 32'h00000008);
        check("R11 irq on set+clear", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_unmapped();
        wr(10'h078, 32'hFFFFFFFF);
        rd_check("R12 read 0x78", 10'h078, 32'h0);
        rd_check("R12 read 0x3FC", 10'h3FC, 32'h0);
        wr(10'h06D, 32'h00000000);
        rd_check("R12 misaligned write ignored", 10'h06C, 32'hA5A55A5A);
        rd_check("R12 misaligned read zero", 10'h06D, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_plain();
        t_osc();
        t_readonly();
        t_en6();
        t_flags();
        t_unmapped();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule